// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address, made of a segment selector and an offset inside that segment, into a physical address. It uses a small table of segment descriptors held in flip-flops. Each descriptor carries:

- a starting physical address;
- a segment length;
- a present flag;
- three access-right bits, one each for load, store and instruction fetch.

Software-side logic fills the table through a single write port. The address pipeline then issues one lookup per cycle. Each lookup carries an access kind.

For every lookup the unit checks three conditions and reports the first one that fails. It first checks that the descriptor is present. It then checks that the offset lies inside the segment length. Last, it checks that the descriptor permits the access kind. If all three pass, the unit adds the offset to the segment start and returns the physical address. Otherwise it returns a fault code that names the failure, and the address reads zero. Results are registered and appear one cycle after the request, with a strobe.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every descriptor is not present and `rsp_valid` is low, so a lookup of any selector before programming returns fault code 1.
- R2: A descriptor write (`cfg_we` high) takes effect at the clock edge. A lookup in the same cycle as a write to the same selector is judged against the old descriptor contents.
- R3: A permitted lookup returns fault code 0 and `rsp_paddr` = start + zero-extended offset, modulo 2^32.
- R4: A lookup of a descriptor whose present flag is 0 returns fault code 1, whatever its length and rights.
- R5: A lookup with offset greater than or equal to the segment length returns fault code 2. A length of 0 faults on every offset. This check takes precedence over the rights check.
- R6: The access kind is encoded as follows: 0 = load, which needs `cfg_perm` bit 0; 1 = store, which needs bit 1; 2 = fetch, which needs bit 2; 3 is reserved and always faults. A missing right returns fault code 3.
- R7: Each lookup with `req_valid` high produces exactly one result, with `rsp_valid` high on the cycle after the request. `rsp_paddr` is 0 whenever the fault code is non-zero. `rsp_paddr` and `rsp_trap` are both 0 whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 4 | Selector of the descriptor to write |
| cfg_base | input | 32 | Segment start physical address |
| cfg_limit | input | 32 | Segment length |
| cfg_valid | input | 1 | Present flag |
| cfg_perm | input | 3 | Rights: bit0 load, bit1 store, bit2 fetch |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | 4 | Segment selector of the lookup |
| req_off | input | 28 | Offset within the segment |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 reserved) |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_trap | output | 2 | Fault code: 0 none, 1 not present, 2 out of bounds, 3 no right |

## Verification
The hardest situations to reach are the fault-ordering cases. In each of them a descriptor fails more than one check at once:

- absent and zero length;
- present, out of bounds, and with no rights.

The stimulus programs descriptors built to fail several checks together, so that only the precedence decides the code. A lookup issued in the same cycle as a write to its own selector is also stimulated, which exercises the old-contents rule. The bench also drives offsets one below and exactly at the length, and a start address near the top of the space so that the sum wraps.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  parameter int unsigned SEG_W  = 4;
  parameter int unsigned OFF_W  = 28;
  parameter int unsigned ADDR_W = 32;
  localparam int unsigned N_SEG = 1 << SEG_W;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_BOUND = 2'd2,
    FLT_RIGHT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic              present;
    logic [2:0]        rights;
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] length;
  } desc_t;
endpackage

// File: rtl/segxl_rst_sync.sv
module segxl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      rst_q  <= stage1;
    end
  end
endmodule

// File: rtl/segxl_table.sv
module segxl_table
  import segxl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_q,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  desc_t            wr_desc,
  input  logic [SEG_W-1:0] rd_idx,
  output desc_t            rd_desc
);
  desc_t slots [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_slot
    logic  hit;
    desc_t slot_d;

    assign hit = wr_en && (wr_idx == SEG_W'(g));

    always_comb begin
      slot_d = slots[g];
      if (hit) slot_d = wr_desc;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) slots[g] <= '0;
      else        slots[g] <= slot_d;
    end
  end

  assign rd_desc = slots[rd_idx];
endmodule

// File: rtl/segxl_judge.sv
module segxl_judge
  import segxl_pkg::*;
(
  input  desc_t             desc,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        kind,
  output logic [1:0]        fault,
  output logic [ADDR_W-1:0] paddr
);
  localparam int unsigned PAD_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic              allowed;

  assign off_ext = {{PAD_W{1'b0}}, off};

  always_comb begin
    case (acc_e'(kind))
      ACC_LOAD:  allowed = desc.rights[0];
      ACC_STORE: allowed = desc.rights[1];
      ACC_FETCH: allowed = desc.rights[2];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    fault = FLT_NONE;
    paddr = '0;
    if (!desc.present)               fault = FLT_ABSENT;
    else if (off_ext >= desc.length) fault = FLT_BOUND;
    else if (!allowed)               fault = FLT_RIGHT;
    else                             paddr = desc.start + off_ext;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segxl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_perm,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_trap
);
  logic              rst_q;
  desc_t             wr_desc;
  desc_t             rd_desc;
  logic [1:0]        j_fault;
  logic [ADDR_W-1:0] j_paddr;
  logic              valid_d;
  logic [ADDR_W-1:0] paddr_d;
  logic [1:0]        trap_d;

  segxl_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign wr_desc = '{present: cfg_valid, rights: cfg_perm,
                     start: cfg_base, length: cfg_limit};

  segxl_table u_tab (
    .clk     (clk),
    .rst_q   (rst_q),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_desc (wr_desc),
    .rd_idx  (req_seg),
    .rd_desc (rd_desc)
  );

  segxl_judge u_judge (
    .desc  (rd_desc),
    .off   (req_off),
    .kind  (req_kind),
    .fault (j_fault),
    .paddr (j_paddr)
  );

  always_comb begin
    valid_d = req_valid;
    paddr_d = req_valid ? j_paddr : '0;
    trap_d  = req_valid ? j_fault : FLT_NONE;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_trap  <= FLT_NONE;
    end else begin
      rsp_valid <= valid_d;
      rsp_paddr <= paddr_d;
      rsp_trap  <= trap_d;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import segxl_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_trap
);
  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid |=> rsp_valid); // R7
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> !rsp_valid); // R7
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_valid && rsp_trap != 2'd0) |-> rsp_paddr == '0); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !rsp_valid |-> (rsp_paddr == '0 && rsp_trap == 2'd0)); // R7
  AST_RSVD_KIND_FAULTS: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_kind == 2'd3) |=> rsp_trap != 2'd0); // R6
endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_trap  (rsp_trap)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_valid, req_valid;
  logic [3:0]  cfg_idx, req_seg;
  logic [31:0] cfg_base, cfg_limit;
  logic [2:0]  cfg_perm;
  logic [27:0] req_off;
  logic [1:0]  req_kind;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_trap;

  typedef struct packed {
    logic        v;
    logic [31:0] pa;
    logic [1:0]  tr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  logic [31:0] m_base [16];
  logic [31:0] m_lim  [16];
  logic        m_val  [16];
  logic [2:0]  m_perm [16];

  always #4 clk = ~clk;

  seg_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
    .cfg_perm(cfg_perm), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .req_kind(req_kind), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap)
  );

  function automatic exp_t model(input logic rv, input logic [3:0] s,
                                 input logic [27:0] o, input logic [1:0] k);
    exp_t  e;
    logic  ok;
    e = '0;
    if (!rv) return e;
    e.v = 1'b1;
    ok = (k == 2'd0) ? m_perm[s][0] : (k == 2'd1) ? m_perm[s][1] :
         (k == 2'd2) ? m_perm[s][2] : 1'b0;
    if (!m_val[s])                  e.tr = 2'd1;
    else if ({4'd0, o} >= m_lim[s]) e.tr = 2'd2;
    else if (!ok)                   e.tr = 2'd3;
    else                            e.pa = m_base[s] + {4'd0, o};
    return e;
  endfunction

  task automatic cyc(input logic we, input logic [3:0] wi, input logic [31:0] wb,
                     input logic [31:0] wl, input logic wv, input logic [2:0] wp,
                     input logic rv, input logic [3:0] s, input logic [27:0] o,
                     input logic [1:0] k, input string tag);
    @(negedge clk);
    cfg_we = we; cfg_idx = wi; cfg_base = wb; cfg_limit = wl;
    cfg_valid = wv; cfg_perm = wp;
    req_valid = rv; req_seg = s; req_off = o; req_kind = k;
    exp_q.push_back(model(rv, s, o, k));
    tag_q.push_back(tag);
    if (we) begin
      m_base[wi] = wb; m_lim[wi] = wl; m_val[wi] = wv; m_perm[wi] = wp;
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] b, input logic [31:0] l,
                    input logic v, input logic [2:0] p);
    cyc(1'b1, i, b, l, v, p, 1'b0, 4'd0, 28'd0, 2'd0, "R2 write");
  endtask

  task automatic rd(input logic [3:0] s, input logic [27:0] o, input logic [1:0] k,
                    input string tag);
    cyc(1'b0, 4'd0, 32'd0, 32'd0, 1'b0, 3'd0, 1'b1, s, o, k, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 4'd0, 32'd0, 32'd0, 1'b0, 3'd0, 1'b0, 4'd0, 28'd0, 2'd0, tag);
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (rsp_valid !== e.v || rsp_paddr !== e.pa || rsp_trap !== e.tr) begin
          n_bad++;
          $display("FAIL %s: got v=%0b pa=%h tr=%0d, expected v=%0b pa=%h tr=%0d",
                   t, rsp_valid, rsp_paddr, rsp_trap, e.v, e.pa, e.tr);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_val[i] = 1'b0; m_perm[i] = '0;
    end
    rst_n = 1'b0;
    cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0; cfg_valid = 0; cfg_perm = 0;
    req_valid = 0; req_seg = 0; req_off = 0; req_kind = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got rsp_valid=%0b, expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(4'd5, 28'd0, 2'd0, "R1 unprogrammed lookup");
    rd(4'd15, 28'h123, 2'd2, "R1 unprogrammed lookup high selector");
    // same-cycle write and lookup of selector 3 sees old (absent) contents
    cyc(1'b1, 4'd3, 32'h1000_0000, 32'h100, 1'b1, 3'b101,
        1'b1, 4'd3, 28'h10, 2'd0, "R2 same-cycle old contents");
    rd(4'd3, 28'h10, 2'd0, "R3 load translate");
    rd(4'd3, 28'hFF, 2'd0, "R5 offset one below length");
    rd(4'd3, 28'h100, 2'd0, "R5 offset equal to length");
    rd(4'd3, 28'h20, 2'd1, "R6 store without right");
    rd(4'd3, 28'h20, 2'd2, "R6 fetch allowed");
    rd(4'd3, 28'h20, 2'd3, "R6 reserved kind");
    idle("R7 idle cycle quiet");
    wr(4'd4, 32'h2000_0000, 32'h0, 1'b0, 3'b111);
    rd(4'd4, 28'h0, 2'd0, "R4 absent precedes bound");
    wr(4'd6, 32'h3000_0000, 32'h10, 1'b1, 3'b000);
    rd(4'd6, 28'h20, 2'd1, "R5 bound precedes rights");
    rd(4'd6, 28'h0, 2'd1, "R6 no rights");
    wr(4'd9, 32'h4000_0000, 32'h0, 1'b1, 3'b111);
    rd(4'd9, 28'h0, 2'd0, "R5 zero length");
    wr(4'd7, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1'b1, 3'b111);
    rd(4'd7, 28'h200, 2'd1, "R3 wrap modulo 2^32");
    wr(4'd8, 32'hF000_0000, 32'hFFFF_FFFF, 1'b1, 3'b010);
    rd(4'd8, 28'hFFF_FFFF, 2'd1, "R3 max offset store");
    rd(4'd8, 28'hFFF_FFFF, 2'd0, "R6 load without right");
    // back-to-back lookups across selectors
    rd(4'd3, 28'h0, 2'd2, "R7 back-to-back a");
    rd(4'd7, 28'h1, 2'd0, "R7 back-to-back b");
    rd(4'd4, 28'h1, 2'd0, "R7 back-to-back c");
    // disable selector 3, then look it up
    wr(4'd3, 32'h1000_0000, 32'h100, 1'b0, 3'b111);
    rd(4'd3, 28'h10, 2'd0, "R2 overwrite to absent");
    wr(4'd4, 32'h0000_0040, 32'h40, 1'b1, 3'b001);
    rd(4'd4, 28'h3F, 2'd0, "R2 rewrite to present");
    for (int i = 0; i < 16; i++) rd(4'(i), 28'(i * 3), 2'(i), "R3 sweep");
    idle("R7 drain");
    idle("R7 drain");
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule